// File: doc/BRIEF.md
# Addressable LED Serial Stream Controller

This block drives a daisy chain of single-wire addressable RGB LEDs. Pixel words of 24 bits are written into a 32-entry FIFO. Each word is taken out, its three bytes are rearranged by a per-slot selection field, and its bits go out most significant first. Every bit is a high pulse followed by a low pulse. A 0 and a 1 each have their own high and low widths, counted in clock cycles. The first LED in the chain takes the first 24 bits it sees and passes the rest on.

Software writes the configuration and pulses `en_set` to start a frame. The block counts the pixels it has finished. When that count reaches `total_len`, it raises `finish_irq`, drops its own enable, and holds the line low for `rst_cyc` cycles so that the LEDs latch the frame. While the block is enabled and the FIFO is at or below a threshold, it asks for more data. The request goes out on `dma_req` in DMA mode and on `cpu_req_irq` otherwise. If the FIFO runs dry between pixels, a programmable low gap is inserted, and a bit is never cut short.

Top module: `ledstrm_ctrl`

## Requirements
- R1: After reset, `led_out`, `finish_irq`, `dma_req`, `cpu_req_irq`, `enabled` and `fifo_full` are all 0.
- R2: The FIFO holds 32 pixels. `fifo_full` is 1 when it holds 32, and a write while full is dropped without disturbing the stored words.
- R3: Transmit slot k (k=0 goes first) takes its byte from `byte_order[2k+1:2k]`: value 0 picks `wr_pixel[7:0]`, 1 picks `[15:8]`, 2 picks `[23:16]`, and 3 sends 8'h00.
- R4: The rearranged 24-bit word is sent MSB first. A 1 is high for `t1_hi` cycles and then low for `t1_lo` cycles. A 0 is high for `t0_hi` cycles and then low for `t0_lo` cycles. Consecutive pixels that are already in the FIFO follow with no extra low time.
- R5: If the FIFO is empty when a pixel ends and the frame is not complete, the line stays low for the last bit's low time, plus `gap_cyc` cycles, plus one cycle, before the next pixel starts.
- R6: When the finished-pixel count equals `total_len`, `finish_irq` is set and `enabled` drops in the same cycle. `en_set` restarts the count from zero.
- R7: After the last bit of a frame, the line stays low for `rst_cyc` cycles, and no pixel starts before that interval has elapsed.
- R8: While the block is enabled and the FIFO level is at or below `req_thresh`, a request is raised on the next cycle. It goes out on `dma_req` when `dma_mode`=1 and on `cpu_req_irq` when `dma_mode`=0, and it is withdrawn once the FIFO is full or the block is disabled.
- R9: `finish_clr` clears `finish_irq`. `soft_rst` clears `finish_irq`, empties the FIFO and disables the block.
- R10: `led_out` is never high while `enabled` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_set | input | 1 | Pulse: enable and restart the pixel count |
| soft_rst | input | 1 | Pulse: clear the finish flag, flush the FIFO, disable |
| finish_clr | input | 1 | Pulse: clear `finish_irq` |
| dma_mode | input | 1 | 1 routes the refill request to `dma_req`, 0 to `cpu_req_irq` |
| byte_order | input | 6 | Three 2-bit byte selectors, one per transmit slot |
| t0_hi | input | CW | High cycles of a 0 bit |
| t0_lo | input | CW | Low cycles of a 0 bit |
| t1_hi | input | CW | High cycles of a 1 bit |
| t1_lo | input | CW | Low cycles of a 1 bit |
| gap_cyc | input | CW | Extra low cycles after an underrun |
| rst_cyc | input | RW | Low cycles that close a frame |
| total_len | input | LW | Pixels per frame (at least 1) |
| req_thresh | input | clog2(DEPTH+1) | FIFO level at or below which a refill is requested |
| wr_valid | input | 1 | Write strobe for `wr_pixel` |
| wr_pixel | input | 24 | Pixel word |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| enabled | output | 1 | Enable state |
| dma_req | output | 1 | Refill request in DMA mode |
| cpu_req_irq | output | 1 | Refill interrupt in CPU mode |
| finish_irq | output | 1 | Frame-finished flag |
| led_out | output | 1 | Serial line to the LED chain |

## Verification
The hardest conditions to reach from the ports are the two exact low-time boundaries. One is the underrun gap, and the other is the closing low interval followed by a new frame. Each appears only when the FIFO contents and the enable are timed against the serializer's internal phase. The bench decodes the line into bits and pixels. It writes the next pixel only after it has seen the previous pixel finish plus a fixed cycle offset, which lands the write inside the gap. It pulses `en_set` right after `finish_irq` rises, while a second pixel is already waiting. The measured low run then equals the exact cycle sum of the last bit's low time, the gap or closing interval, and the one pickup cycle.

// File: rtl/ledstrm_pkg.sv
package ledstrm_pkg;
   localparam int PIX_W  = 24;
   localparam int BYTE_W = 8;
   localparam int NSLOT  = PIX_W / BYTE_W;
   localparam int SEL_W  = 2;

   typedef logic [PIX_W-1:0] pix_t;

   typedef enum logic [2:0] {
      SER_IDLE,
      SER_HIGH,
      SER_LOW,
      SER_GAP,
      SER_CLOSE
   } ser_state_e;
endpackage

// File: rtl/ledstrm_fifo.sv
module ledstrm_fifo #(
   parameter int W     = 24,
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int LVW  = $clog2(DEPTH + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           flush,
   input  logic           wr_en,
   input  logic [W-1:0]   wr_data,
   input  logic           rd_en,
   output logic [W-1:0]   rd_data,
   output logic [LVW-1:0] level,
   output logic           full,
   output logic           empty
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_wr, do_rd;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("ledstrm_fifo: DEPTH must be a power of two, at least 2");
   end

   assign full    = (level == LVW'(DEPTH));
   assign empty   = (level == '0);
   assign do_wr   = wr_en && !full && !flush;
   assign do_rd   = rd_en && !empty && !flush;
   assign rd_data = mem[rp];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (do_wr) wp <= wp + AW'(1);
         if (do_rd) rp <= rp + AW'(1);
         case ({do_wr, do_rd})
            2'b10:   level <= level + LVW'(1);
            2'b01:   level <= level - LVW'(1);
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/ledstrm_reorder.sv
module ledstrm_reorder
   import ledstrm_pkg::*;
(
   input  pix_t                     pix_in,
   input  logic [NSLOT*SEL_W-1:0]   order,
   output pix_t                     pix_out
);
   for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      logic [SEL_W-1:0]  sel;
      logic [BYTE_W-1:0] pick;
      assign sel = order[k*SEL_W +: SEL_W];
      always_comb begin
         pick = '0;
         for (int b = 0; b < NSLOT; b++) begin
            if (sel == SEL_W'(b)) pick = pix_in[b*BYTE_W +: BYTE_W];
         end
      end
      assign pix_out[PIX_W-1-k*BYTE_W -: BYTE_W] = pick;
   end
endmodule

// File: rtl/ledstrm_ser.sv
module ledstrm_ser
   import ledstrm_pkg::*;
#(
   parameter int CW  = 8,
   parameter int RW  = 17,
   localparam int KW = (CW > RW) ? CW : RW,
   localparam int BW = $clog2(PIX_W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          en,
   input  logic [CW-1:0] t0_hi,
   input  logic [CW-1:0] t0_lo,
   input  logic [CW-1:0] t1_hi,
   input  logic [CW-1:0] t1_lo,
   input  logic [CW-1:0] gap_cyc,
   input  logic [RW-1:0] rst_cyc,
   input  logic          fifo_empty,
   input  pix_t          pix_in,
   input  logic          last_pix,
   output logic          pop,
   output logic          pix_done,
   output logic          frame_done,
   output logic          line
);
   ser_state_e    st;
   pix_t          sh;
   logic [BW-1:0] bidx;
   logic [KW-1:0] cnt;
   logic          cnt_end, can_load;

   assign cnt_end    = (cnt <= KW'(1));
   assign can_load   = en && !fifo_empty;
   assign pix_done   = (st == SER_LOW) && cnt_end && (bidx == '0);
   assign frame_done = pix_done && last_pix;
   assign pop        = ((st == SER_IDLE) && can_load) ||
                       (pix_done && !last_pix && can_load);
   assign line       = (st == SER_HIGH);

   function automatic logic [KW-1:0] hi_of(input logic b);
      return b ? KW'(t1_hi) : KW'(t0_hi);
   endfunction

   function automatic logic [KW-1:0] lo_of(input logic b);
      return b ? KW'(t1_lo) : KW'(t0_lo);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= SER_IDLE;
         sh   <= '0;
         bidx <= '0;
         cnt  <= '0;
      end else if (flush) begin
         st   <= SER_IDLE;
         cnt  <= '0;
      end else begin
         case (st)
            SER_IDLE: begin
               if (can_load) begin
                  sh   <= pix_in;
                  bidx <= BW'(PIX_W - 1);
                  cnt  <= hi_of(pix_in[PIX_W-1]);
                  st   <= SER_HIGH;
               end
            end
            SER_HIGH: begin
               if (cnt_end) begin
                  cnt <= lo_of(sh[PIX_W-1]);
                  st  <= SER_LOW;
               end else begin
                  cnt <= cnt - KW'(1);
               end
            end
            SER_LOW: begin
               if (!cnt_end) begin
                  cnt <= cnt - KW'(1);
               end else if (bidx != '0) begin
                  sh   <= sh << 1;
                  bidx <= bidx - BW'(1);
                  cnt  <= hi_of(sh[PIX_W-2]);
                  st   <= SER_HIGH;
               end else if (last_pix) begin
                  cnt <= KW'(rst_cyc);
                  st  <= SER_CLOSE;
               end else if (can_load) begin
                  sh   <= pix_in;
                  bidx <= BW'(PIX_W - 1);
                  cnt  <= hi_of(pix_in[PIX_W-1]);
                  st   <= SER_HIGH;
               end else if (gap_cyc != '0) begin
                  cnt <= KW'(gap_cyc);
                  st  <= SER_GAP;
               end else begin
                  st  <= SER_IDLE;
               end
            end
            SER_GAP, SER_CLOSE: begin
               if (cnt_end) st <= SER_IDLE;
               else         cnt <= cnt - KW'(1);
            end
            default: st <= SER_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ledstrm_ctrl.sv
module ledstrm_ctrl
   import ledstrm_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int CW    = 8,
   parameter int RW    = 17,
   parameter int LW    = 11,
   localparam int LVW  = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_set,
   input  logic             soft_rst,
   input  logic             finish_clr,
   input  logic             dma_mode,
   input  logic [5:0]       byte_order,
   input  logic [CW-1:0]    t0_hi,
   input  logic [CW-1:0]    t0_lo,
   input  logic [CW-1:0]    t1_hi,
   input  logic [CW-1:0]    t1_lo,
   input  logic [CW-1:0]    gap_cyc,
   input  logic [RW-1:0]    rst_cyc,
   input  logic [LW-1:0]    total_len,
   input  logic [LVW-1:0]   req_thresh,
   input  logic             wr_valid,
   input  logic [23:0]      wr_pixel,
   output logic             fifo_full,
   output logic             enabled,
   output logic             dma_req,
   output logic             cpu_req_irq,
   output logic             finish_irq,
   output logic             led_out
);
   if (CW < 2 || RW < CW || LW < 1) begin : g_bad_width
      $error("ledstrm_ctrl: need CW >= 2, RW >= CW, LW >= 1");
   end
   if (NSLOT * SEL_W != 6) begin : g_bad_order
      $error("ledstrm_ctrl: byte_order width does not match slot count");
   end

   pix_t           fifo_q, ordered;
   logic [LVW-1:0] level;
   logic           fifo_empty, pop, pix_done, frame_done;
   logic [LW-1:0]  pix_cnt;
   logic           last_pix, req_q;

   ledstrm_fifo #(.W(PIX_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (soft_rst),
      .wr_en   (wr_valid),
      .wr_data (wr_pixel),
      .rd_en   (pop),
      .rd_data (fifo_q),
      .level   (level),
      .full    (fifo_full),
      .empty   (fifo_empty)
   );

   ledstrm_reorder u_reorder (
      .pix_in  (fifo_q),
      .order   (byte_order),
      .pix_out (ordered)
   );

   ledstrm_ser #(.CW(CW), .RW(RW)) u_ser (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (soft_rst),
      .en         (enabled),
      .t0_hi      (t0_hi),
      .t0_lo      (t0_lo),
      .t1_hi      (t1_hi),
      .t1_lo      (t1_lo),
      .gap_cyc    (gap_cyc),
      .rst_cyc    (rst_cyc),
      .fifo_empty (fifo_empty),
      .pix_in     (ordered),
      .last_pix   (last_pix),
      .pop        (pop),
      .pix_done   (pix_done),
      .frame_done (frame_done),
      .line       (led_out)
   );

   assign last_pix = ((pix_cnt + LW'(1)) == total_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enabled    <= 1'b0;
         pix_cnt    <= '0;
         finish_irq <= 1'b0;
         req_q      <= 1'b0;
      end else begin
         if (soft_rst)        enabled <= 1'b0;
         else if (en_set)     enabled <= 1'b1;
         else if (frame_done) enabled <= 1'b0;

         if (soft_rst || en_set) pix_cnt <= '0;
         else if (pix_done)      pix_cnt <= pix_cnt + LW'(1);

         if (soft_rst)        finish_irq <= 1'b0;
         else if (frame_done) finish_irq <= 1'b1;
         else if (finish_clr) finish_irq <= 1'b0;

         if (soft_rst || !enabled || fifo_full) req_q <= 1'b0;
         else if (level <= req_thresh)          req_q <= 1'b1;
      end
   end

   assign dma_req     = req_q && dma_mode;
   assign cpu_req_irq = req_q && !dma_mode;
endmodule

// File: rtl/ledstrm_chk.sv
module ledstrm_chk #(
   parameter int CW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          en_set,
   input logic          soft_rst,
   input logic          finish_clr,
   input logic [CW-1:0] t0_hi,
   input logic [CW-1:0] t1_hi,
   input logic          enabled,
   input logic          fifo_full,
   input logic          dma_req,
   input logic          cpu_req_irq,
   input logic          finish_irq,
   input logic          led_out
);
   logic [CW:0] hi_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hi_run <= '0;
      else if (led_out) hi_run <= hi_run + (CW+1)'(1);
      else              hi_run <= '0;
   end

   p_line_low_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      led_out |-> enabled);

   p_finish_disables_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(finish_irq) |-> (!enabled || $past(en_set)));

   p_req_drop_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |=> !(dma_req || cpu_req_irq));

   p_req_off_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !enabled |=> !(dma_req || cpu_req_irq));

   p_high_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(led_out) |-> (hi_run == {1'b0, t0_hi} || hi_run == {1'b0, t1_hi}));

   p_finish_clear_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(finish_irq) |-> ($past(finish_clr) || $past(soft_rst)));
endmodule

bind ledstrm_ctrl ledstrm_chk #(.CW(CW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en_set      (en_set),
   .soft_rst    (soft_rst),
   .finish_clr  (finish_clr),
   .t0_hi       (t0_hi),
   .t1_hi       (t1_hi),
   .enabled     (enabled),
   .fifo_full   (fifo_full),
   .dma_req     (dma_req),
   .cpu_req_irq (cpu_req_irq),
   .finish_irq  (finish_irq),
   .led_out     (led_out)
);

// File: tb/sim_ledstrm_ctrl.sv
module sim_ledstrm_ctrl;
   localparam int CW = 8, RW = 17, LW = 11, LVW = 6;
   localparam int T0H = 2, T0L = 5, T1H = 5, T1L = 2, GAP = 10, RSTC = 40;

   // {byte_order[5:0], pixel[23:0], expected transmitted word[23:0]}
   localparam logic [53:0] VEC [7] = '{
      {6'h06, 24'hA1B2C3, 24'hA1B2C3},
      {6'h24, 24'hA1B2C3, 24'hC3B2A1},
      {6'h09, 24'hA1B2C3, 24'hB2A1C3},
      {6'h3C, 24'hA1B2C3, 24'hC30000},
      {6'h12, 24'hA1B2C3, 24'hA1C3B2},
      {6'h06, 24'hFFFFFF, 24'hFFFFFF},
      {6'h06, 24'h000000, 24'h000000}
   };

   logic clk = 0, rst_n = 0;
   logic en_set = 0, soft_rst = 0, finish_clr = 0, dma_mode = 1, wr_valid = 0;
   logic [5:0] byte_order = 6'h06;
   logic [CW-1:0] t0_hi = T0H, t0_lo = T0L, t1_hi = T1H, t1_lo = T1L, gap_cyc = GAP;
   logic [RW-1:0] rst_cyc = RSTC;
   logic [LW-1:0] total_len = 1;
   logic [LVW-1:0] req_thresh = 30;
   logic [23:0] wr_pixel = 0;
   logic fifo_full, enabled, dma_req, cpu_req_irq, finish_irq, led_out;

   ledstrm_ctrl u0 (.*);

   always #2 clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 0;

   // line decoder
   logic [23:0] rx_q [64];
   int rx_n = 0, rx_bits = 0, run = 0, hi_bad = 0, lo_bad = 0, bnd_bad = 0, bnd_last = 0;
   bit prev = 0, last_bit = 0, bnd_chk = 0;
   logic [23:0] rx_word = 0;

   always @(negedge clk) begin
      cyc++;
      if (led_out) begin
         if (!prev) begin
            if (rx_bits != 0) begin
               if (run != (last_bit ? T1L : T0L)) lo_bad++;
            end else begin
               bnd_last = run;
               if (bnd_chk && rx_n > 0 && run != (last_bit ? T1L : T0L)) bnd_bad++;
            end
            run = 1;
         end else run++;
      end else begin
         if (prev) begin
            if (run == T1H) last_bit = 1;
            else if (run == T0H) last_bit = 0;
            else hi_bad++;
            rx_word = {rx_word[22:0], last_bit};
            rx_bits++;
            if (rx_bits == 24) begin
               if (rx_n < 64) rx_q[rx_n] = rx_word;
               rx_n++;
               rx_bits = 0;
            end
            run = 1;
         end else run++;
      end
      prev = led_out;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic pulse_en();  en_set = 1;     tick(); en_set = 0;     endtask
   task automatic pulse_clr(); finish_clr = 1; tick(); finish_clr = 0; endtask
   task automatic pulse_srst(); soft_rst = 1;  tick(); soft_rst = 0;   endtask

   task automatic push(input logic [23:0] p);
      wr_valid = 1; wr_pixel = p; tick(); wr_valid = 0;
   endtask

   task automatic wait_finish(input int lim);
      for (int i = 0; i < lim && !finish_irq; i++) tick();
   endtask

   task automatic wait_rx(input int n, input int lim);
      for (int i = 0; i < lim && rx_n < n; i++) tick();
   endtask

   function automatic logic [23:0] pix_of(input int i);
      return {8'(i), 8'(i) ^ 8'h5A, 8'(3 * i + 1)};
   endfunction

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      done = 1;
      $finish;
   endtask

   initial begin
      while (cyc < 150000) @(negedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
         finish_run();
      end
   end

   initial begin
      bit hi_seen;
      tick(5);
      @(negedge clk);
      chk(led_out == 0 && finish_irq == 0 && dma_req == 0 && cpu_req_irq == 0
          && enabled == 0 && fifo_full == 0, "R1 reset state",
          {led_out, finish_irq, dma_req, cpu_req_irq, enabled, fifo_full}, 0);
      rst_n = 1;
      tick(3);

      // R3/R4/R6/R9: one pixel per vector, table-driven
      foreach (VEC[v]) begin
         rx_n = 0; rx_bits = 0;
         byte_order = VEC[v][53:48];
         total_len = 1;
         push(VEC[v][47:24]);
         pulse_en();
         wait_finish(1000);
         @(negedge clk);
         chk(rx_n == 1 && rx_q[0] == VEC[v][23:0], "R3/R4 byte order and bit coding",
             rx_q[0], VEC[v][23:0]);
         chk(finish_irq == 1 && enabled == 0, "R6 finish sets flag and disables",
             {finish_irq, enabled}, 2'b10);
         tick();
         pulse_clr();
         @(negedge clk);
         chk(finish_irq == 0, "R9 finish_clr clears flag", finish_irq, 0);
         tick(RSTC + 5);
      end
      chk(hi_bad == 0 && lo_bad == 0, "R4 pulse widths within pixels", hi_bad + lo_bad, 0);

      // R2/R8: fill FIFO while disabled, 33rd write dropped
      byte_order = 6'h06;
      rx_n = 0; rx_bits = 0; bnd_chk = 1;
      for (int i = 0; i < 33; i++) push(pix_of(i));
      @(negedge clk);
      chk(fifo_full == 1, "R2 full at 32 entries", fifo_full, 1);
      chk(dma_req == 0 && cpu_req_irq == 0, "R8 no request while disabled",
          {dma_req, cpu_req_irq}, 0);
      total_len = 32; dma_mode = 1; req_thresh = 30;
      tick();
      pulse_en();
      tick(20);
      @(negedge clk);
      chk(dma_req == 0, "R8 no request above threshold", dma_req, 0);
      for (int i = 0; i < 1000 && !dma_req; i++) tick();
      @(negedge clk);
      chk(dma_req == 1 && cpu_req_irq == 0, "R8 DMA request at threshold",
          {dma_req, cpu_req_irq}, 2'b10);
      dma_mode = 0;
      #1;
      chk(dma_req == 0 && cpu_req_irq == 1, "R8 CPU interrupt request in CPU mode",
          {dma_req, cpu_req_irq}, 2'b01);
      dma_mode = 1;
      wait_finish(8000);
      tick(2);
      begin
         int bad = 0;
         for (int i = 0; i < 32; i++) if (rx_q[i] != pix_of(i)) bad++;
         chk(rx_n == 32 && bad == 0, "R2 first 32 words sent, overflow write dropped", rx_n, 32);
      end
      chk(bnd_bad == 0, "R4 no extra low time between queued pixels", bnd_bad, 0);
      @(negedge clk);
      chk(dma_req == 0 && cpu_req_irq == 0, "R8 request withdrawn after disable",
          {dma_req, cpu_req_irq}, 0);
      bnd_chk = 0;
      tick();
      pulse_clr();
      tick(RSTC + 5);

      // R5: underrun gap
      rx_n = 0; rx_bits = 0;
      total_len = 2;
      push(24'h000001);
      pulse_en();
      wait_rx(1, 1000);
      tick(6);
      @(negedge clk);
      chk(finish_irq == 0 && enabled == 1, "R6 no finish before count reached",
          {finish_irq, enabled}, 2'b01);
      push(24'h800000);
      wait_finish(1000);
      @(negedge clk);
      chk(rx_n == 2 && rx_q[1] == 24'h800000, "R5 second pixel after gap", rx_q[1], 24'h800000);
      chk(bnd_last == T1L + GAP + 1, "R5 underrun low run", bnd_last, T1L + GAP + 1);
      tick();
      pulse_clr();
      tick(RSTC + 5);

      // R7: closing low interval, re-enable with data waiting
      rx_n = 0; rx_bits = 0;
      total_len = 1;
      push(24'h000001);
      push(24'h800000);
      pulse_en();
      wait_finish(1000);
      @(negedge clk);
      chk(enabled == 0, "R6 enable cleared at finish", enabled, 0);
      tick();
      en_set = 1; finish_clr = 1;
      tick();
      en_set = 0; finish_clr = 0;
      wait_rx(2, 1000);
      chk(bnd_last == T1L + RSTC + 1, "R7 closing low interval", bnd_last, T1L + RSTC + 1);
      wait_finish(500);
      @(negedge clk);
      chk(finish_irq == 1, "R6 count restarts on en_set", finish_irq, 1);
      tick(RSTC + 5);

      // R10: data waiting while disabled keeps line low
      rx_n = 0; rx_bits = 0;
      for (int i = 0; i < 3; i++) push(pix_of(i + 40));
      hi_seen = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (led_out) hi_seen = 1;
      end
      chk(hi_seen == 0, "R10 line low while disabled", hi_seen, 0);

      // R9: soft reset clears flag, flushes FIFO, disables
      #1;
      pulse_srst();
      @(negedge clk);
      chk(finish_irq == 0 && enabled == 0, "R9 soft reset clears flag and enable",
          {finish_irq, enabled}, 0);
      tick();
      pulse_en();
      hi_seen = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (led_out) hi_seen = 1;
      end
      chk(hi_seen == 0 && rx_n == 0, "R9 soft reset flushed FIFO", rx_n, 0);
      #1;
      pulse_srst();
      tick(2);
      finish_run();
   end
endmodule